// File: doc/BRIEF.md
# Hall Commutation Decoder with Brake

This block turns three digitised rotor-position sensor signals into the six gate enables of a three-phase brushless bridge. There is one high-side and one low-side enable per phase, for phases U, V and W. A sensor code picks one phase whose high side conducts and one phase whose low side conducts. A direction input reverses rotation by inverting the sensor code before it is decoded.

A chop input modulates the active low side. While it is low, the high side of the same phase conducts instead, so the winding current freewheels through a switch rather than a diode. A start/stop input, a short-brake input and a low-side inhibit override the commutation. Each phase leg guarantees a programmable dead time before any of its switches turns on.

All gate enables come from registers. A change at the inputs reaches the gates one clock later when it only turns switches off. Turning a switch on can be delayed further by the dead time.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_rev`=0, `run_n`=0, `brake_req`=0 and `pwm_on`=1, the sensor code {hall_in[2],hall_in[1],hall_in[0]} selects (high side, low side) as: 101→(V,U), 100→(W,U), 110→(W,V), 010→(U,V), 011→(U,W), 001→(V,W). All other gates are off.
- R2: With `dir_rev`=1 the gates are those that R1 gives for the bitwise inverse of the sensor code.
- R3: A sensor code of 000 or 111 turns every gate off, unless braking.
- R4: `run_n`=1 turns every gate off, whatever the other inputs are.
- R5: `brake_req`=1 with `run_n`=0 turns on all three low sides and turns off all three high sides, whatever the sensor code, direction and `pwm_on`.
- R6: Only the low side selected by the sensor code follows `pwm_on`. While `pwm_on`=0 that low side is off and the high side of the same phase is on. The selected high side stays on through both chop levels.
- R7: Within one phase, a gate turns on only after both gates of that phase have been off for `DEAD_CYC` consecutive cycles (default 4). A leg that has been idle that long, or is just out of reset, turns on one cycle after the request.
- R8: `low_inhibit`=1 turns off all three low sides, including during braking, and leaves the high sides as the other rules give them.
- R9: The high and low gates of one phase are never on in the same cycle.
- R10: Reset is synchronous and active low and clears every gate. A request that only turns gates off is reflected one clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hall_in | input | 3 | Sensor code; bit 2 is the first sensor, bit 0 the third |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| run_n | input | 1 | 0 run, 1 stop |
| brake_req | input | 1 | 1 applies the short brake |
| pwm_on | input | 1 | Chop level for the active low side |
| low_inhibit | input | 1 | 1 forces all low sides off |
| gate_uh | output | 1 | Phase U high-side enable |
| gate_vh | output | 1 | Phase V high-side enable |
| gate_wh | output | 1 | Phase W high-side enable |
| gate_ul | output | 1 | Phase U low-side enable |
| gate_vl | output | 1 | Phase V low-side enable |
| gate_wl | output | 1 | Phase W low-side enable |

## Verification
A brake request can arrive while a leg is still inside the dead-time window that a chop edge has opened. The leg that was waiting to turn its high side on must then turn its low side on instead. The bench provokes this by dropping `pwm_on` and asserting `brake_req` one cycle later. It then checks that the waiting high side never turns on, that the idle leg's low side turns on at once, and that each of the two disturbed legs turns its low side on exactly `DEAD_CYC` cycles after it went off.

// File: rtl/bldc_pkg.sv
// Shared types for the commutation decoder.
// Assumes three phases, ordered U, V, W at indices 0, 1, 2.
package bldc_pkg;
    localparam int NPH = 3;

    // Drive request (and state) of one bridge leg
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_req_t;
endpackage

// File: rtl/bldc_hall_decode.sv
// Sensor code decoder: maps the three sensor bits and the direction to a
// one-hot high-side phase and a one-hot low-side phase.
// Assumes the code is {first, second, third} sensor; purely combinational.
module bldc_hall_decode
    import bldc_pkg::*;
(
    input  logic [2:0]     hall,
    input  logic           rev,
    output logic           valid,
    output logic [NPH-1:0] hi_oh,
    output logic [NPH-1:0] lo_oh
);
    logic [2:0] code;

    // Reverse rotation uses the inverted code on the forward table
    assign code = rev ? ~hall : hall;

    // Forward six-step table; the two uniform codes are invalid
    always_comb begin
        valid = 1'b1;
        hi_oh = '0;
        lo_oh = '0;
        case (code)
            3'b101: begin hi_oh = 3'b010; lo_oh = 3'b001; end
            3'b100: begin hi_oh = 3'b100; lo_oh = 3'b001; end
            3'b110: begin hi_oh = 3'b100; lo_oh = 3'b010; end
            3'b010: begin hi_oh = 3'b001; lo_oh = 3'b010; end
            3'b011: begin hi_oh = 3'b001; lo_oh = 3'b100; end
            3'b001: begin hi_oh = 3'b010; lo_oh = 3'b100; end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/bldc_leg_request.sv
// Per-phase request arbiter: combines the decoded phases with stop, brake,
// chop and low-side inhibit into one drive request per leg.
// Priority: stop, then low inhibit on low requests, then brake, then table.
module bldc_leg_request
    import bldc_pkg::*;
(
    input  logic                     run_n,
    input  logic                     brake,
    input  logic                     pwm,
    input  logic                     kill_lo,
    input  logic                     valid,
    input  logic [NPH-1:0]           hi_oh,
    input  logic [NPH-1:0]           lo_oh,
    output leg_req_t [NPH-1:0]       req_o
);
    for (genvar p = 0; p < NPH; p++) begin : g_ph
        leg_req_t r;

        // Resolve the request of this phase
        always_comb begin
            r = LEG_OFF;
            if (!run_n) begin
                if (brake) begin
                    r = LEG_LO;
                end else if (valid) begin
                    if (hi_oh[p]) begin
                        r = LEG_HI;
                    end else if (lo_oh[p]) begin
                        r = pwm ? LEG_LO : LEG_HI;
                    end
                end
                if (kill_lo && (r == LEG_LO)) begin
                    r = LEG_OFF;
                end
            end
        end

        assign req_o[p] = r;
    end
endmodule

// File: rtl/bldc_leg.sv
// One bridge leg with dead-time insertion. Turn-off is taken at the next
// edge. Turn-on waits until the leg has been fully off for DEAD_CYC cycles.
// Assumes DEAD_CYC >= 1. Reset leaves the wait already satisfied.
module bldc_leg
    import bldc_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_t req,
    output logic     hi,
    output logic     lo
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_FULL = CW'(DEAD_CYC);

    leg_req_t      st_q;
    logic [CW-1:0] gap_q;

    // Leg state machine with off-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LEG_OFF;
            gap_q <= GAP_FULL;
        end else if (st_q != LEG_OFF) begin
            if (req != st_q) begin
                st_q  <= LEG_OFF;
                gap_q <= CW'(1);
            end
        end else if ((req != LEG_OFF) && (gap_q == GAP_FULL)) begin
            st_q <= req;
        end else if (gap_q != GAP_FULL) begin
            gap_q <= gap_q + CW'(1);
        end
    end

    assign hi = (st_q == LEG_HI);
    assign lo = (st_q == LEG_LO);

    // Checker: independent count of cycles with both gates observed off
    logic [CW-1:0] idle_chk_q;

    // Track observed off-run length of the gate pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_chk_q <= GAP_FULL;
        end else if (hi || lo) begin
            idle_chk_q <= '0;
        end else if (idle_chk_q != GAP_FULL) begin
            idle_chk_q <= idle_chk_q + CW'(1);
        end
    end

    // R7
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi && !lo) |=> (!(hi || lo) || (idle_chk_q == GAP_FULL)))
        else $error("gate turned on before dead time elapsed");

    // R7
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi || lo) |=> !(hi && $past(lo)) && !(lo && $past(hi)))
        else $error("leg swapped sides without an off gap");

    initial begin
        if (DEAD_CYC < 1) $error("DEAD_CYC must be at least 1");
    end
endmodule

// File: rtl/bldc_commutator.sv
// Top: sensor-code commutation with direction, stop, short brake, chop
// with synchronous rectification, low-side inhibit and per-leg dead time.
// Assumes sensor inputs are already synchronised to clk.
module bldc_commutator #(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_in,
    input  logic       dir_rev,
    input  logic       run_n,
    input  logic       brake_req,
    input  logic       pwm_on,
    input  logic       low_inhibit,
    output logic       gate_uh,
    output logic       gate_vh,
    output logic       gate_wh,
    output logic       gate_ul,
    output logic       gate_vl,
    output logic       gate_wl
);
    import bldc_pkg::*;

    logic                 valid;
    logic [NPH-1:0]       hi_oh;
    logic [NPH-1:0]       lo_oh;
    leg_req_t [NPH-1:0]   leg_req;
    logic [NPH-1:0]       hi_v;
    logic [NPH-1:0]       lo_v;

    bldc_hall_decode u_dec (
        .hall  (hall_in),
        .rev   (dir_rev),
        .valid (valid),
        .hi_oh (hi_oh),
        .lo_oh (lo_oh)
    );

    bldc_leg_request u_req (
        .run_n   (run_n),
        .brake   (brake_req),
        .pwm     (pwm_on),
        .kill_lo (low_inhibit),
        .valid   (valid),
        .hi_oh   (hi_oh),
        .lo_oh   (lo_oh),
        .req_o   (leg_req)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        bldc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (leg_req[p]),
            .hi    (hi_v[p]),
            .lo    (lo_v[p])
        );
    end

    assign gate_uh = hi_v[0];
    assign gate_vh = hi_v[1];
    assign gate_wh = hi_v[2];
    assign gate_ul = lo_v[0];
    assign gate_vl = lo_v[1];
    assign gate_wl = lo_v[2];

    // R4
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_n |=> ({gate_uh, gate_vh, gate_wh, gate_ul, gate_vl, gate_wl} == 6'b0))
        else $error("gates on while stopped");

    // R8
    low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_inhibit |=> ({gate_ul, gate_vl, gate_wl} == 3'b0))
        else $error("low side on while inhibited");

    // R5
    brake_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_req && !run_n) |=> ({gate_uh, gate_vh, gate_wh} == 3'b0))
        else $error("high side on while braking");

    // R3
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake_req && ((hall_in == 3'b000) || (hall_in == 3'b111)))
        |=> ({gate_uh, gate_vh, gate_wh, gate_ul, gate_vl, gate_wl} == 6'b0))
        else $error("gates on with a uniform sensor code");

    // R9
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (({gate_uh, gate_vh, gate_wh} & {gate_ul, gate_vl, gate_wl}) == 3'b0))
        else $error("shoot-through on a leg");
endmodule

// File: tb/test_bldc_commutator.sv
`timescale 1ns/1ps
module test_bldc_commutator;
    localparam int DEAD = 4;
    localparam int NV   = 22;

    // Vector: {hall[2:0], rev, pwm, brake, run_n, kill, exp{uh,vh,wh,ul,vl,wl}}
    localparam logic [13:0] VEC [NV] = '{
        {3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010_100}, // R1
        {3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b001_100}, // R1
        {3'b110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b001_010}, // R1
        {3'b010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100_010}, // R1
        {3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100_001}, // R1
        {3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010_001}, // R1
        {3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010_100}, // R2
        {3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b001_100}, // R2
        {3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b001_010}, // R2
        {3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100_010}, // R2
        {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100_001}, // R2
        {3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010_001}, // R2
        {3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R3
        {3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000_000}, // R3
        {3'b101, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'b000_000}, // R4
        {3'b101, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b000_000}, // R4
        {3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000_111}, // R5
        {3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000_111}, // R5
        {3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'b010_000}, // R8
        {3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000_000}, // R8
        {3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b110_000}, // R6
        {3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'b011_000}  // R6
    };
    localparam int VREQ [NV] = '{1,1,1,1,1,1,2,2,2,2,2,2,3,3,4,4,5,5,8,8,6,6};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b101;
    logic       dir_rev = 1'b0;
    logic       run_n = 1'b0;
    logic       brake_req = 1'b0;
    logic       pwm_on = 1'b1;
    logic       low_inhibit = 1'b0;
    logic       gate_uh, gate_vh, gate_wh, gate_ul, gate_vl, gate_wl;

    int total = 0;
    int bad = 0;
    int shoot = 0;

    always #2.5 clk = ~clk;

    bldc_commutator #(.DEAD_CYC(DEAD)) i_bldc_commutator (
        .clk         (clk),
        .rst_n       (rst_n),
        .hall_in     (hall_in),
        .dir_rev     (dir_rev),
        .run_n       (run_n),
        .brake_req   (brake_req),
        .pwm_on      (pwm_on),
        .low_inhibit (low_inhibit),
        .gate_uh     (gate_uh),
        .gate_vh     (gate_vh),
        .gate_wh     (gate_wh),
        .gate_ul     (gate_ul),
        .gate_vl     (gate_vl),
        .gate_wl     (gate_wl)
    );

    function automatic logic [5:0] gates();
        return {gate_uh, gate_vh, gate_wh, gate_ul, gate_vl, gate_wl};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    // Continuous leg overlap monitor (R9)
    always @(negedge clk) begin
        if (rst_n && ((gates() >> 3) & gates() & 6'b000_111) != 0) shoot++;
    end

    task automatic finish_run();
        check("R9 shoot-through samples", shoot, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        // R10: reset holds every gate off even with a drive request present
        repeat (3) @(negedge clk);
        check("R10 reset state", 32'(gates()), 0);
        rst_n = 1'b1;

        // Table of static cases
        for (int i = 0; i < NV; i++) begin
            {hall_in, dir_rev, pwm_on, brake_req, run_n, low_inhibit} = VEC[i][13:6];
            settle();
            check($sformatf("R%0d vector %0d", VREQ[i], i), 32'(gates()), 32'(VEC[i][5:0]));
        end

        // R6/R7: chop falling, low off next edge, high on after DEAD off cycles
        {hall_in, dir_rev, pwm_on, brake_req, run_n, low_inhibit} = {3'b101, 5'b0_1_0_0_0};
        settle();
        pwm_on = 1'b0;
        @(negedge clk);
        check("R10 chop low turn-off latency", 32'(gate_ul), 0);
        n = 0;
        while (!gate_uh && n < 20) begin n++; @(negedge clk); end
        check("R7 dead cycles before U high", n, DEAD);
        check("R6 V high held through chop", 32'(gate_vh), 1);

        // R7: chop rising, low returns after DEAD off cycles
        pwm_on = 1'b1;
        @(negedge clk);
        check("R7 U high off after chop rise", 32'(gate_uh), 0);
        n = 0;
        while (!gate_ul && n < 20) begin n++; @(negedge clk); end
        check("R7 dead cycles before U low", n, DEAD);

        // R7: from long idle, turn-on takes one edge
        run_n = 1'b1;
        settle();
        run_n = 1'b0;
        @(negedge clk);
        check("R7 idle leg turn-on", 32'({gate_vh, gate_ul}), 3);

        // R8: inhibit removes an active low side at the next edge
        low_inhibit = 1'b1;
        @(negedge clk);
        check("R8 inhibit latency", 32'(gate_ul), 0);
        low_inhibit = 1'b0;
        settle();

        // R5/R7: brake arriving inside a chop dead-time window
        pwm_on = 1'b0;
        @(negedge clk);
        brake_req = 1'b1;
        @(negedge clk);
        check("R5 idle W low on at once", 32'(gate_wl), 1);
        check("R5 highs off during brake", 32'({gate_uh, gate_vh}), 0);
        repeat (3) @(negedge clk);
        check("R7 U low after dead time", 32'({gate_ul, gate_vl}), 2);
        @(negedge clk);
        check("R7 V low after dead time", 32'(gate_vl), 1);
        check("R5 brake pattern", 32'(gates()), 32'(6'b000_111));

        // R10: synchronous reset mid-run clears gates at next edge
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset mid-run", 32'(gates()), 0);
        rst_n = 1'b1;
        settle();

        finish_run();
    end
endmodule